// File: doc/BRIEF.md
# Ethernet frame header classifier

The classifier watches a received Ethernet frame as it streams past in 32-bit words and builds a 32-bit information word about it, which a control processor reads to decide how the frame is handled. Each word is big-endian: byte 0 of the word sits in bits 31:24. The frame starts at the destination MAC address, with no alignment padding in front of it. The frame data is only observed and is never modified.

The block compares the destination MAC with this node's 48-bit address and recognises IPv4 and ARP from the EtherType. For IPv4 frames it checks the 20-byte header checksum, compares the destination IP with the node's 32-bit address, and recognises ICMP and UDP. For UDP frames it compares the destination port with the node's 16-bit control port. The receive MAC reports per-frame error causes with the last word, and the block folds these in with a summary bit. The flags are nested, so each flag implies its parent flag. The information word is published with a one-cycle strobe when the last word is accepted. It reads zero from the first word of the next frame until that frame ends.

Top module: `eth_hdr_classifier`

## Requirements
- R1: While reset is held and afterwards until the first frame ends, info_word reads 0 and info_valid is low.
- R2: The cycle after the clock edge that accepts the last word (in_valid and in_eop high), info_word holds the result and info_valid is high for exactly that one cycle. The word then holds until the next frame starts.
- R3: A first word (in_valid and in_sop high, in_eop low) clears info_word to 0 at that edge. A word with both in_sop and in_eop high is a one-word frame, and its own result is published.
- R4: Bit 7 is set when word 0 equals node_mac[47:16] and word 1 bits 31:16 equal node_mac[15:0].
- R5: Bits 31:16 of word 3 hold the EtherType. Bit 9 is set for 0x0800 (IPv4) and bit 8 for 0x0806 (ARP).
- R6: Bit 10 is set only if bit 9 is set, the header-length nibble in word 3 bits 11:8 equals 5, the frame reaches word 8, and the ones-complement sum of the ten header halfwords folds to 0xFFFF. The halfwords are word 3 bits 15:0, words 4 to 7 both halves, and word 8 bits 31:16.
- R7: Bit 11 is set when bit 9 is set and the destination IP (word 7 bits 15:0, word 8 bits 31:16) equals node_ip.
- R8: The protocol byte is word 5 bits 7:0. With bit 9 set, bit 12 marks protocol 1 (ICMP) and bit 13 marks protocol 17 (UDP).
- R9: Bit 14 is set when bit 13 is set and the UDP destination port in word 9 bits 31:16 equals ctrl_port.
- R10: in_err is taken with the last word. Its bit 4 (collision), bit 3 (PHY error), bit 2 (FIFO-overflow truncation), bit 1 (CRC error) and bit 0 (bad length) appear at info_word bits 5, 4, 3, 2 and 1, and bit 0 is the OR of bits 5:1.
- R11: Bit 6 and bits 31:15 of info_word always read 0.
- R12: Cycles with in_valid low are ignored, whatever in_sop, in_eop and in_data carry. A frame with idle gaps gives the same result as the same frame sent without gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | A frame word is present this cycle |
| in_sop | input | 1 | The present word is the first word of a frame |
| in_eop | input | 1 | The present word is the last word of a frame |
| in_data | input | 32 | Frame word, byte 0 in bits 31:24 |
| in_err | input | 5 | Receive MAC error causes, valid with the last word |
| node_mac | input | 48 | This node's MAC address |
| node_ip | input | 32 | This node's IPv4 address |
| ctrl_port | input | 16 | This node's UDP control port |
| info_word | output | 32 | Frame information word |
| info_valid | output | 1 | One-cycle strobe when info_word is updated |

## Verification
The clear at a frame's first word and the publish at its last word fall on the same edge when a frame is one word long. The bench provokes this with a one-word frame carrying error bits, sent right after a frame whose result was nonzero. It judges the case correct when the one-word frame's own result (error field only, no MAC match) appears with the strobe, and not zero and not the earlier value. A first word followed by an idle pause is also checked: info_word must read zero during the pause, and the frame must then complete normally.

// File: rtl/eth_hdr_cls_pkg.sv
package eth_hdr_cls_pkg;
  localparam int WORD_W = 32;
  localparam int MAC_W  = 48;
  localparam int IP_W   = 32;
  localparam int PORT_W = 16;
  localparam int ERR_W  = 5;
  localparam int INFO_W = 32;
  localparam int IDX_W  = 4;
  localparam int SUM_W  = 20;
  localparam int HALF_W = WORD_W / 2;

  localparam logic [15:0] ETYPE_IPV4 = 16'h0800;
  localparam logic [15:0] ETYPE_ARP  = 16'h0806;
  localparam logic [7:0]  PROTO_ICMP = 8'd1;
  localparam logic [7:0]  PROTO_UDP  = 8'd17;
  localparam logic [3:0]  IHL_PLAIN  = 4'd5;

  localparam logic [IDX_W-1:0] W_MAC_HI = 4'd0;
  localparam logic [IDX_W-1:0] W_MAC_LO = 4'd1;
  localparam logic [IDX_W-1:0] W_ETYPE  = 4'd3;
  localparam logic [IDX_W-1:0] W_HDR4   = 4'd4;
  localparam logic [IDX_W-1:0] W_PROTO  = 4'd5;
  localparam logic [IDX_W-1:0] W_HDR6   = 4'd6;
  localparam logic [IDX_W-1:0] W_DIP_HI = 4'd7;
  localparam logic [IDX_W-1:0] W_DIP_LO = 4'd8;
  localparam logic [IDX_W-1:0] W_PORT   = 4'd9;

  localparam int B_MAC   = 7;
  localparam int B_ARP   = 8;
  localparam int B_IP    = 9;
  localparam int B_CSUM  = 10;
  localparam int B_IPM   = 11;
  localparam int B_ICMP  = 12;
  localparam int B_UDP   = 13;
  localparam int B_CTRL  = 14;

  typedef struct packed {
    logic        mac_hi;
    logic        mac_lo;
    logic [15:0] etype;
    logic        ihl_ok;
    logic [7:0]  proto;
    logic        dip_hi;
    logic        dip_lo;
    logic        port_ok;
  } hdr_fields_t;
endpackage

// File: rtl/eth_hdr_word_track.sv
module eth_hdr_word_track
  import eth_hdr_cls_pkg::*;
#(
  parameter int DW = WORD_W,
  parameter int MW = MAC_W,
  parameter int IW = IP_W,
  parameter int PW = PORT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic [DW-1:0]     in_data,
  input  logic [MW-1:0]     node_mac,
  input  logic [IW-1:0]     node_ip,
  input  logic [PW-1:0]     ctrl_port,
  output logic [IDX_W-1:0]  idx,
  output hdr_fields_t       fld_nxt
);
  localparam int MAC_LO_W = MW - DW;
  localparam int HW       = DW / 2;

  logic [IDX_W-1:0] cnt_q, cnt_nxt;
  hdr_fields_t      fld_q, base;
  logic             start;

  always_comb begin
    start   = in_valid && in_sop;
    idx     = in_sop ? '0 : cnt_q;
    base    = start ? '0 : fld_q;
    fld_nxt = base;
    cnt_nxt = cnt_q;
    if (in_valid) begin
      cnt_nxt = (idx == '1) ? idx : idx + 1'b1;
      case (idx)
        W_MAC_HI: fld_nxt.mac_hi  = (in_data == node_mac[MW-1 -: DW]);
        W_MAC_LO: fld_nxt.mac_lo  = (in_data[DW-1 -: MAC_LO_W] == node_mac[MAC_LO_W-1:0]);
        W_ETYPE: begin
          fld_nxt.etype  = in_data[DW-1 -: 16];
          fld_nxt.ihl_ok = (in_data[11:8] == IHL_PLAIN);
        end
        W_PROTO:  fld_nxt.proto   = in_data[7:0];
        W_DIP_HI: fld_nxt.dip_hi  = (in_data[HW-1:0] == node_ip[IW-1 -: HW]);
        W_DIP_LO: fld_nxt.dip_lo  = (in_data[DW-1 -: HW] == node_ip[HW-1:0]);
        W_PORT:   fld_nxt.port_ok = (in_data[DW-1 -: PW] == ctrl_port);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      fld_q <= '0;
    end else if (in_valid) begin
      cnt_q <= cnt_nxt;
      fld_q <= fld_nxt;
    end
  end
endmodule

// File: rtl/eth_hdr_csum_acc.sv
module eth_hdr_csum_acc
  import eth_hdr_cls_pkg::*;
#(
  parameter int DW = WORD_W,
  parameter int SW = SUM_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sop,
  input  logic [IDX_W-1:0] idx,
  input  logic [DW-1:0]    in_data,
  output logic             csum_good
);
  localparam int HW = DW / 2;

  logic [SW-1:0] sum_q, sum_nxt, base_sum, add;
  logic          done_q, done_nxt;
  logic [HW:0]   fold1;
  logic [HW-1:0] fold2;
  logic [SW-1:0] hi, lo;

  always_comb begin
    hi       = SW'(in_data[DW-1 -: HW]);
    lo       = SW'(in_data[HW-1:0]);
    base_sum = (in_valid && in_sop) ? '0 : sum_q;
    done_nxt = (in_valid && in_sop) ? 1'b0 : done_q;
    add      = '0;
    case (idx)
      W_ETYPE:                    add = lo;
      W_HDR4, W_PROTO, W_HDR6,
      W_DIP_HI:                   add = hi + lo;
      W_DIP_LO:                   add = hi;
      default:                    add = '0;
    endcase
    sum_nxt = base_sum;
    if (in_valid) begin
      sum_nxt = base_sum + add;
      if (idx == W_DIP_LO) done_nxt = 1'b1;
    end
    fold1     = {1'b0, sum_nxt[HW-1:0]} + (HW+1)'(sum_nxt[SW-1:HW]);
    fold2     = fold1[HW-1:0] + HW'(fold1[HW]);
    csum_good = done_nxt && (fold2 == '1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q  <= '0;
      done_q <= 1'b0;
    end else if (in_valid) begin
      sum_q  <= sum_nxt;
      done_q <= done_nxt;
    end
  end
endmodule

// File: rtl/eth_hdr_info_pack.sv
module eth_hdr_info_pack
  import eth_hdr_cls_pkg::*;
#(
  parameter int EW = ERR_W,
  parameter int OW = INFO_W
) (
  input  hdr_fields_t    fld,
  input  logic           csum_good,
  input  logic [EW-1:0]  err,
  output logic [OW-1:0]  info
);
  logic is_ip, is_udp;

  always_comb begin
    is_ip  = (fld.etype == ETYPE_IPV4);
    is_udp = is_ip && (fld.proto == PROTO_UDP);
    info   = '0;
    info[EW:1]   = err;
    info[0]      = |err;
    info[B_MAC]  = fld.mac_hi && fld.mac_lo;
    info[B_ARP]  = (fld.etype == ETYPE_ARP);
    info[B_IP]   = is_ip;
    info[B_CSUM] = is_ip && fld.ihl_ok && csum_good;
    info[B_IPM]  = is_ip && fld.dip_hi && fld.dip_lo;
    info[B_ICMP] = is_ip && (fld.proto == PROTO_ICMP);
    info[B_UDP]  = is_udp;
    info[B_CTRL] = is_udp && fld.port_ok;
  end
endmodule

// File: rtl/eth_hdr_classifier.sv
module eth_hdr_classifier
  import eth_hdr_cls_pkg::*;
#(
  parameter int DW = WORD_W,
  parameter int MW = MAC_W,
  parameter int IW = IP_W,
  parameter int PW = PORT_W,
  parameter int EW = ERR_W,
  parameter int OW = INFO_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sop,
  input  logic          in_eop,
  input  logic [DW-1:0] in_data,
  input  logic [EW-1:0] in_err,
  input  logic [MW-1:0] node_mac,
  input  logic [IW-1:0] node_ip,
  input  logic [PW-1:0] ctrl_port,
  output logic [OW-1:0] info_word,
  output logic          info_valid
);
  logic [1:0]       rst_pipe;
  logic             rst_int;
  logic [IDX_W-1:0] idx;
  hdr_fields_t      fld_nxt;
  logic             csum_good;
  logic [OW-1:0]    packed_info, info_nxt, info_q;
  logic             vld_nxt, vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int = rst_pipe[1];

  eth_hdr_word_track #(.DW(DW), .MW(MW), .IW(IW), .PW(PW)) track_i (
    .clk(clk), .rst_n(rst_int), .in_valid(in_valid), .in_sop(in_sop),
    .in_data(in_data), .node_mac(node_mac), .node_ip(node_ip),
    .ctrl_port(ctrl_port), .idx(idx), .fld_nxt(fld_nxt)
  );

  eth_hdr_csum_acc #(.DW(DW)) csum_i (
    .clk(clk), .rst_n(rst_int), .in_valid(in_valid), .in_sop(in_sop),
    .idx(idx), .in_data(in_data), .csum_good(csum_good)
  );

  eth_hdr_info_pack #(.EW(EW), .OW(OW)) pack_i (
    .fld(fld_nxt), .csum_good(csum_good), .err(in_err), .info(packed_info)
  );

  always_comb begin
    vld_nxt  = in_valid && in_eop;
    info_nxt = info_q;
    if (in_valid && in_eop)      info_nxt = packed_info;
    else if (in_valid && in_sop) info_nxt = '0;
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) begin
      info_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      info_q <= info_nxt;
      vld_q  <= vld_nxt;
    end
  end

  assign info_word  = info_q;
  assign info_valid = vld_q;
endmodule

// File: rtl/eth_hdr_classifier_chk.sv
module eth_hdr_classifier_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_sop,
  input logic        in_eop,
  input logic [31:0] info_word,
  input logic        info_valid
);
  assert_strobe_after_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    info_valid |-> $past(in_valid && in_eop));

  assert_hold_between_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> $stable(info_word));

  assert_clear_at_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && in_sop && !in_eop) |-> (info_word == 32'd0));

  assert_csum_needs_ip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    info_word[10] |-> info_word[9]);

  assert_ipmatch_needs_ip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    info_word[11] |-> info_word[9]);

  assert_proto_needs_ip_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (info_word[12] || info_word[13]) |-> (info_word[9] && !(info_word[12] && info_word[13])));

  assert_ctrl_needs_udp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    info_word[14] |-> info_word[13]);

  assert_err_summary_R10: assert property (@(posedge clk) disable iff (!rst_n)
    info_word[0] == (|info_word[5:1]));

  assert_reserved_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (info_word[31:15] == 17'd0) && !info_word[6]);

  assert_arp_ip_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(info_word[8] && info_word[9]));
endmodule

bind eth_hdr_classifier eth_hdr_classifier_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
  .in_eop(in_eop), .info_word(info_word), .info_valid(info_valid)
);

// File: tb/eth_hdr_classifier_tb_top.sv
`timescale 1ns/1ps
module eth_hdr_classifier_tb_top;
  localparam logic [47:0] NODE_MAC = 48'h0200_1122_3344;
  localparam logic [31:0] NODE_IP  = 32'h0A00_0105;
  localparam logic [15:0] CTRL     = 16'h1388;
  localparam logic [31:0] SRC_IP   = 32'h0A00_0102;

  typedef struct packed {
    logic        mac_ok;
    logic [15:0] etype;
    logic [7:0]  verihl;
    logic [7:0]  proto;
    logic        ip_ok;
    logic        port_ok;
    logic        csum_bad;
    logic [4:0]  err;
    logic [3:0]  nw;
    logic [14:0] exp;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 16'h0800, 8'h45, 8'd17, 1'b1, 1'b1, 1'b0, 5'b00000, 4'd12, 15'h6E80},
    '{1'b0, 16'h0806, 8'h45, 8'd17, 1'b1, 1'b1, 1'b0, 5'b00000, 4'd12, 15'h0100},
    '{1'b1, 16'h0800, 8'h45, 8'd1,  1'b0, 1'b0, 1'b0, 5'b00000, 4'd12, 15'h1680},
    '{1'b1, 16'h0800, 8'h45, 8'd17, 1'b1, 1'b0, 1'b1, 5'b00000, 4'd12, 15'h2A80},
    '{1'b1, 16'h0800, 8'h46, 8'd17, 1'b1, 1'b1, 1'b0, 5'b00000, 4'd12, 15'h6A80},
    '{1'b1, 16'h0800, 8'h45, 8'd17, 1'b1, 1'b1, 1'b0, 5'b10010, 4'd12, 15'h6EA5},
    '{1'b1, 16'h0800, 8'h45, 8'd17, 1'b1, 1'b1, 1'b0, 5'b00001, 4'd8,  15'h2283},
    '{1'b1, 16'h86DD, 8'h45, 8'd17, 1'b1, 1'b1, 1'b0, 5'b01100, 4'd12, 15'h0099}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_sop, in_eop;
  logic [31:0] in_data;
  logic [4:0]  in_err;
  logic [31:0] info_word;
  logic        info_valid;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;
  logic [31:0] frm [12];
  logic [4:0]  cur_err;

  always #2.5 clk = ~clk;

  eth_hdr_classifier dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
    .in_eop(in_eop), .in_data(in_data), .in_err(in_err),
    .node_mac(NODE_MAC), .node_ip(NODE_IP), .ctrl_port(CTRL),
    .info_word(info_word), .info_valid(info_valid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic build(input vec_t v);
    logic [31:0] dip;
    logic [15:0] dport, cs;
    logic [19:0] s;
    logic [16:0] f;
    dip   = v.ip_ok ? NODE_IP : (NODE_IP ^ 32'h0000_0100);
    dport = v.port_ok ? CTRL : (CTRL ^ 16'h0001);
    frm[0]  = v.mac_ok ? NODE_MAC[47:16] : (NODE_MAC[47:16] ^ 32'h1);
    frm[1]  = {NODE_MAC[15:0], 16'hAABB};
    frm[2]  = 32'hCCDD_EEFF;
    frm[3]  = {v.etype, v.verihl, 8'h00};
    frm[4]  = 32'h0030_1234;
    frm[5]  = {16'h4000, 8'h40, v.proto};
    frm[6]  = {16'h0000, SRC_IP[31:16]};
    frm[7]  = {SRC_IP[15:0], dip[31:16]};
    frm[8]  = {dip[15:0], 16'h0400};
    frm[9]  = {dport, 16'h0010};
    frm[10] = 32'h0102_0304;
    frm[11] = 32'h0506_0708;
    s = 20'(frm[3][15:0]) + 20'(frm[4][31:16]) + 20'(frm[4][15:0]) +
        20'(frm[5][31:16]) + 20'(frm[5][15:0]) + 20'(frm[6][15:0]) +
        20'(frm[7][31:16]) + 20'(frm[7][15:0]) + 20'(frm[8][31:16]);
    f  = {1'b0, s[15:0]} + 17'(s[19:16]);
    f  = {1'b0, f[15:0]} + 17'(f[16]);
    cs = ~f[15:0];
    if (v.csum_bad) cs = cs ^ 16'h0001;
    frm[6][31:16] = cs;
    cur_err = v.err;
  endtask

  task automatic send(input int first, input int nw, input int gap);
    for (int i = first; i < nw; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_sop   = (i == 0);
      in_eop   = (i == nw - 1);
      in_data  = frm[i];
      in_err   = (i == nw - 1) ? cur_err : 5'd0;
      if (i < nw - 1) begin
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          in_valid = 1'b0;
          in_sop   = 1'b1;
          in_eop   = 1'b1;
          in_data  = 32'hDEAD_BEEF;
          in_err   = 5'h1F;
        end
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_sop   = 1'b0;
    in_eop   = 1'b0;
    in_data  = 32'd0;
    in_err   = 5'd0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    in_data = 32'd0; in_err = 5'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset word", info_word, 32'd0);
    check("R1 reset strobe", {31'd0, info_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", info_word, 32'd0);

    for (int k = 0; k < NV; k++) begin
      build(TBL[k]);
      send(0, int'(TBL[k].nw), 0);
      check("R2 strobe high", {31'd0, info_valid}, 32'd1);
      check("table R4 R5 R6 R7 R8 R9 R10 R11 result", info_word, {17'd0, TBL[k].exp});
      @(negedge clk);
      check("R2 strobe one cycle", {31'd0, info_valid}, 32'd0);
      check("R2 hold", info_word, {17'd0, TBL[k].exp});
    end

    // R3: first word then pause clears; R12: frame resumes after pause
    build(TBL[0]);
    @(negedge clk);
    in_valid = 1'b1; in_sop = 1'b1; in_eop = 1'b0; in_data = frm[0]; in_err = 5'd0;
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0;
    check("R3 clear at first word", info_word, 32'd0);
    repeat (3) @(negedge clk);
    check("R3 stays clear", info_word, 32'd0);
    send(1, 12, 0);
    check("R12 resumed frame", info_word, 32'h0000_6E80);

    // R3: one-word frame publishes its own result
    build(TBL[0]);
    frm[0] = NODE_MAC[47:16];
    cur_err = 5'b00100;
    send(0, 1, 0);
    check("R3 one-word strobe", {31'd0, info_valid}, 32'd1);
    check("R3 one-word result", info_word, 32'h0000_0009);

    // R12: gaps with noise on the other inputs
    build(TBL[2]);
    send(0, 12, 2);
    check("R12 gapped frame", info_word, 32'h0000_1680);

    // R4: low MAC half mismatch only
    build(TBL[0]);
    frm[1] = frm[1] ^ 32'h0001_0000;
    send(0, 12, 0);
    check("R4 low half mismatch", info_word, 32'h0000_6E00);

    // R6: frame ending at word 8 still completes the checksum
    build(TBL[0]);
    send(0, 9, 0);
    check("R6 header complete at word 8", info_word, 32'h0000_2E80);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule